// File: doc/BRIEF.md
# Paged Peripheral Bus Decoder

This block sits between a slow peripheral slot of a host bus and a serial
controller that exposes two registers. The host drives an active-low page
strobe, the low address byte and a read/write line, all timed by a 1 MHz bus
clock. The strobe, the read/write line and the address are captured on that
clock, so a strobe that comes and goes between two bus clock edges never
reaches the controller. The selected pair is decoded from the captured values.

From the captured values the block produces a chip-select, a register-select
taken from the lowest address bit, and the registered read/write line. The bus
clock is passed straight to the controller's enable pin. A toggle stage halves
the bus clock to give the reference for the controller's transmit and receive
bit clocks. That is 500 kHz from a 1 MHz bus clock.

Top module: `pdec_top`

## Requirements
- R1: While rst_ni is low and after it is released, before the first bus clock edge, cs_o is 0, rw_o is 1 (read) and ser_clk_o is 0.
- R2: When pg_ni was 0 and addr_i was 0xFC or 0xFD (bits 7..2 all 1, bit 1 equal to 0) at a rising clk_i edge, cs_o is 1 after that edge.
- R3: When addr_i at a rising edge has any of bits 7..2 at 0 or bit 1 at 1 (for example 0xFE, 0xFF, 0x7C, 0xF8), cs_o is 0 after that edge, whatever pg_ni is.
- R4: When pg_ni was 1 at a rising edge, cs_o is 0 after that edge, even with a matching address.
- R5: After each rising edge, rs_o equals bit 0 of addr_i as sampled at that edge (0 selects offset 0xFC, 1 selects 0xFD).
- R6: After each rising edge, rw_o equals rw_i as sampled at that edge.
- R7: cs_o falls at the first rising edge after pg_ni goes high or addr_i leaves the pair, and not earlier.
- R8: ser_clk_o inverts at every rising edge of clk_i, so its period is two bus clock periods.
- R9: en_o follows clk_i with no register in between.
- R10: A low pulse on pg_ni that starts and ends between two rising edges leaves cs_o at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 1 MHz bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pg_ni | input | 1 | Active-low page strobe |
| addr_i | input | 8 | Low address byte within the page |
| rw_i | input | 1 | Read (1) / write (0) from the host |
| cs_o | output | 1 | Chip-select to the controller, active high |
| rs_o | output | 1 | Register-select to the controller |
| rw_o | output | 1 | Registered read/write to the controller |
| en_o | output | 1 | Controller enable, the bus clock itself |
| ser_clk_o | output | 1 | Bus clock divided by two, for transmit and receive clocks |

## Verification
A wrong captured strobe or address shows as cs_o high for an address outside
the pair, high while the strobe is idle, or low on a real access. Each of these
appears one bus clock after the offending input, and is compared in that cycle.
A stuck or skipped divider stage shows as ser_clk_o failing to invert between
two adjacent rising edges. A capture stage that samples on the wrong edge, or
passes the strobe through without a register, lets a short strobe pulse raise
cs_o or moves rs_o and rw_o by a cycle.

// File: rtl/pdec_pkg.sv
package pdec_pkg;
  localparam int unsigned ADDR_W = 8;

  typedef struct packed {
    logic              pg_n;
    logic              rw;
    logic [ADDR_W-1:0] addr;
  } bus_req_t;

  localparam bus_req_t BUS_IDLE = '{pg_n: 1'b1, rw: 1'b1, addr: '0};
endpackage

// File: rtl/pdec_capture.sv
module pdec_capture
  import pdec_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  bus_req_t req_i,
  output bus_req_t req_q_o
);
  bus_req_t req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= BUS_IDLE;
    else         req_q <= req_i;
  end

  assign req_q_o = req_q;
endmodule

// File: rtl/pdec_match.sv
module pdec_match #(
  parameter int unsigned          ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]    BASE_ADDR = 8'hFC,
  parameter logic [ADDR_W-1:0]    IGN_MASK  = 8'h01
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] bit_ok;

  // one comparator per address bit; ignored bits always agree
  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    if (IGN_MASK[b]) begin : g_ign
      assign bit_ok[b] = 1'b1;
    end else begin : g_cmp
      assign bit_ok[b] = (addr_i[b] == BASE_ADDR[b]);
    end
  end

  assign hit_o = &bit_ok;
endmodule

// File: rtl/pdec_divider.sv
module pdec_divider #(
  parameter int unsigned DIV_LOG2 = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic div_clk_o
);
  logic [DIV_LOG2-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign div_clk_o = cnt_q[DIV_LOG2-1];
endmodule

// File: rtl/pdec_top.sv
module pdec_top
  import pdec_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hFC,
  parameter logic [ADDR_W-1:0] IGN_MASK  = 8'h01,
  parameter int unsigned       DIV_LOG2  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pg_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rw_i,
  output logic              cs_o,
  output logic              rs_o,
  output logic              rw_o,
  output logic              en_o,
  output logic              ser_clk_o
);
  bus_req_t req_d, req_q;
  logic     hit;

  assign req_d = '{pg_n: pg_ni, rw: rw_i, addr: addr_i};

  pdec_capture u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_d),
    .req_q_o (req_q)
  );

  pdec_match #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .IGN_MASK  (IGN_MASK)
  ) u_match (
    .addr_i (req_q.addr),
    .hit_o  (hit)
  );

  pdec_divider #(
    .DIV_LOG2 (DIV_LOG2)
  ) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_clk_o (ser_clk_o)
  );

  assign cs_o = hit & ~req_q.pg_n;
  assign rs_o = req_q.addr[0];
  assign rw_o = req_q.rw;
  assign en_o = clk_i;
endmodule

// File: rtl/pdec_checker.sv
module pdec_checker #(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [7:0]  BASE_ADDR = 8'hFC,
  parameter logic [7:0]  IGN_MASK  = 8'h01
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pg_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rw_i,
  input logic              cs_o,
  input logic              rs_o,
  input logic              rw_o,
  input logic              ser_clk_o
);
  logic in_pair;
  assign in_pair = ((addr_i & ~IGN_MASK) == (BASE_ADDR & ~IGN_MASK));

  p_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pg_ni && in_pair) |=> cs_o);

  p_miss_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_pair |=> !cs_o);

  p_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_ni |=> !cs_o);

  p_regsel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (rs_o == $past(addr_i[0])));

  p_rw_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (rw_o == $past(rw_i)));

  p_toggle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (ser_clk_o != $past(ser_clk_o)));

  // R1: reset values
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_rst_r1: assert (!cs_o && rw_o && !ser_clk_o);
    end
  end
endmodule

bind pdec_top pdec_checker #(
  .ADDR_W    (8),
  .BASE_ADDR (BASE_ADDR),
  .IGN_MASK  (IGN_MASK)
) u_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pg_ni     (pg_ni),
  .addr_i    (addr_i),
  .rw_i      (rw_i),
  .cs_o      (cs_o),
  .rs_o      (rs_o),
  .rw_o      (rw_o),
  .ser_clk_o (ser_clk_o)
);

// File: tb/pdec_top_tb.sv
`timescale 1ns/1ps
module pdec_top_tb;
  localparam time TCK = 8ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pg_n = 1'b1;
  logic [7:0] addr = 8'h00;
  logic       rw = 1'b1;
  logic       cs, rs, rwo, en, ser;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic  cs;
    logic  rs;
    logic  rw;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #(TCK/2) clk = ~clk;

  pdec_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pg_ni(pg_n), .addr_i(addr), .rw_i(rw),
    .cs_o(cs), .rs_o(rs), .rw_o(rwo), .en_o(en), .ser_clk_o(ser)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: apply one bus cycle, push what should appear after the next edge
  task automatic drive(input logic p, input logic [7:0] a, input logic r, input string tag);
    exp_t e;
    @(negedge clk);
    pg_n = p; addr = a; rw = r;
    e.cs  = !p && (a[7:2] == 6'h3F) && !a[1];
    e.rs  = a[0];
    e.rw  = r;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " cs"}, cs, e.cs);
        check("R5 rs", rs, e.rs);
        check("R6 rw", rwo, e.rw);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(TCK * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic prev;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 cs", cs, 1'b0);
    check("R1 rw", rwo, 1'b1);
    check("R1 ser", ser, 1'b0);
    #1 rst_n = 1'b1;
    #1;
    check("R1 cs after release", cs, 1'b0);
    check("R1 ser after release", ser, 1'b0);

    // R2 main selection, both registers, both directions
    drive(1'b0, 8'hFC, 1'b1, "R2 FC read");
    drive(1'b0, 8'hFD, 1'b0, "R2 FD write");
    drive(1'b0, 8'hFC, 1'b0, "R2 FC write");
    // R3 non-matching addresses with strobe active
    drive(1'b0, 8'hFE, 1'b1, "R3 FE");
    drive(1'b0, 8'hFF, 1'b0, "R3 FF");
    drive(1'b0, 8'h7C, 1'b1, "R3 7C");
    drive(1'b0, 8'hF8, 1'b1, "R3 F8");
    drive(1'b0, 8'hBD, 1'b0, "R3 BD");
    // R4 strobe idle with matching address
    drive(1'b1, 8'hFC, 1'b1, "R4 FC idle");
    drive(1'b1, 8'hFD, 1'b0, "R4 FD idle");
    // R7 deassert on address leaving, then on strobe rising
    drive(1'b0, 8'hFD, 1'b1, "R7 setup");
    drive(1'b0, 8'hFE, 1'b1, "R7 addr leaves");
    drive(1'b0, 8'hFC, 1'b1, "R7 reselect");
    drive(1'b1, 8'hFC, 1'b1, "R7 strobe rises");
    repeat (2) @(negedge clk);

    // R7 cs holds until the edge: strobe rises mid-cycle
    drive(1'b0, 8'hFD, 1'b1, "R7 hold");
    @(posedge clk); #2;
    pg_n = 1'b1;
    #1 check("R7 cs held before edge", cs, 1'b1);
    @(posedge clk); #1;
    check("R7 cs low after edge", cs, 1'b0);

    // R10 strobe glitch between edges
    @(negedge clk);
    addr = 8'hFC;
    #1 pg_n = 1'b0;
    #2 pg_n = 1'b1;
    @(posedge clk); #1;
    check("R10 glitch cs", cs, 1'b0);
    @(posedge clk); #1;
    check("R10 glitch cs later", cs, 1'b0);

    // R9 enable follows clock
    @(posedge clk); #1;
    check("R9 en high", en, 1'b1);
    @(negedge clk); #1;
    check("R9 en low", en, 1'b0);

    // R8 divider inverts every edge
    @(posedge clk); #1;
    prev = ser;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      check("R8 ser toggle", ser, ~prev);
      prev = ser;
    end

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule